// File: doc/BRIEF.md
# Serial Video Word Aligner with Sync Correction

This block sits behind the descrambler of a serial digital video receiver. It runs on the serial bit clock, takes one already-descrambled bit per clock, and turns the stream into 10-bit parallel words. A single-cycle strobe marks each new word, and the strobe also serves as the parallel-rate clock enable for the logic downstream. The block finds the word boundary by watching for the timing reference preamble. That preamble is three consecutive words: the first is all ones (3FF hex) and the next two are all zeros (000, 000).

Each detected preamble toggles a horizontal-sync line. A preamble that arrives off the current boundary pulses a sync-error flag. What happens to the word timing after that depends on a mode input:

- With correction off, the block realigns at once to every misaligned preamble.
- With correction on, the block keeps its old timing through the first misaligned preamble. It realigns only if the next preamble is also misaligned.

This guards the parallel timing against a single corrupted sync.

Top module: `sdi_word_aligner`

## Requirements
- R1: While reset is high and in the first cycle after it, word_out, word_stb, hsync and sync_err are all 0. The first word after reset is made of the first ten bits received.
- R2: The first received bit of a word lands in word_out bit 0, and bit 9 is the last received. word_stb is high for exactly one cycle per word. The strobe comes every 10 serial cycles while alignment is unchanged, and word_out changes only together with word_stb.
- R3: A preamble is 30 consecutive bits forming word 3FF followed by words 000 and 000. In the cycle after its last bit is sampled, hsync has inverted.
- R4: A preamble whose last bit completes a word on the current boundary leaves the word timing unchanged and does not pulse sync_err.
- R5: With corr_en low, a misaligned preamble pulses sync_err for one cycle and realigns immediately. In the cycle after its last bit, word_stb presents word 000. The following words are built from the bits that come after the preamble.
- R6: With corr_en high, the first misaligned preamble pulses sync_err, but words keep coming on the old boundary.
- R7: With corr_en high, a misaligned preamble that follows an ignored one, with no aligned preamble in between, pulses sync_err and realigns as in R5.
- R8: An aligned preamble clears the ignored-preamble state, so that the next misaligned preamble is again ignored in correction mode.
- R9: hsync toggles on every preamble, including one that is ignored in correction mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Descrambled serial data bit |
| corr_en | input | 1 | 1 = ignore a single misaligned preamble |
| word_out | output | 10 | Registered parallel word, bit 0 received first |
| word_stb | output | 1 | One-cycle strobe when word_out is new |
| hsync | output | 1 | Toggles once per detected preamble |
| sync_err | output | 1 | One-cycle pulse on a misaligned preamble |

## Verification
The bench slips the stream by a few bits ahead of a preamble, with correction both off and on.

- A design that always snaps to the preamble would emit words on the new boundary when correction is on and the first misaligned preamble arrives.
- A design that never realigns would keep the old boundary after the second misaligned preamble.
- A design that fails to clear its pending state on an aligned preamble would realign on the next single miss. To catch this, the bench restores the old alignment with padding bits, sends an aligned preamble, and then slips again.

Every word is compared against a bit-accurate reference. A reversed bit order or an off-by-one word counter therefore shows up on the very first word after reset.

// File: rtl/sdia_pkg.sv
package sdia_pkg;
  // Classification of one preamble event against the current word phase
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_ALIGNED = 2'd1,
    EV_MISS    = 2'd2
  } sync_ev_e;

  // Next state of the correction-pending flag for a given event
  function automatic logic pend_next(input sync_ev_e ev, input logic corr, input logic pend);
    case (ev)
      EV_ALIGNED: pend_next = 1'b0;
      EV_MISS:    pend_next = corr & ~pend;
      default:    pend_next = pend;
    endcase
  endfunction
endpackage

// File: rtl/sdia_shift_det.sv
module sdia_shift_det #(
  parameter int W = 10,
  parameter int N = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_in,
  output logic [W*N-1:0] sr_nxt,
  output logic           det
);
  localparam int TOT = W * N;

  logic [TOT-1:0] sr_q;
  logic [N-1:0]   wmatch;

  // newest bit enters at the top, so the oldest word sits in the low slice
  assign sr_nxt = {bit_in, sr_q[TOT-1:1]};

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_word
      if (g == 0) begin : g_ones
        assign wmatch[g] = &sr_nxt[g*W +: W];
      end else begin : g_zeros
        assign wmatch[g] = ~|sr_nxt[g*W +: W];
      end
    end
  endgenerate

  assign det = &wmatch;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_nxt;
  end
endmodule

// File: rtl/sdia_phase_ctrl.sv
module sdia_phase_ctrl
  import sdia_pkg::*;
#(
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic det,
  input  logic corr_en,
  output logic miss,
  output logic capture
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          on_bnd;
  logic          realign;
  sync_ev_e      ev;

  assign on_bnd  = (cnt_q == LAST);
  assign ev      = !det ? EV_NONE : (on_bnd ? EV_ALIGNED : EV_MISS);
  assign miss    = (ev == EV_MISS);
  assign realign = miss & (~corr_en | pend_q);
  assign capture = on_bnd | realign;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= capture ? '0 : cnt_q + 1'b1;
      pend_q <= pend_next(ev, corr_en, pend_q);
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);
  // R5
  snap_now_chk: assert property (@(posedge clk) disable iff (rst)
    (det && !on_bnd && !corr_en) |=> (cnt_q == '0));
  // R6
  first_miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (det && !on_bnd && corr_en && !pend_q) |=> (pend_q && cnt_q != '0));
  // R8
  aligned_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (det && on_bnd) |=> !pend_q);
endmodule

// File: rtl/sdia_word_out.sv
module sdia_word_out #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] word_in,
  input  logic         det,
  input  logic         miss,
  output logic [W-1:0] word_out,
  output logic         word_stb,
  output logic         hsync,
  output logic         sync_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_stb <= 1'b0;
      hsync    <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      if (capture) word_out <= word_in;
      word_stb <= capture;
      hsync    <= hsync ^ det;
      sync_err <= miss;
    end
  end

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_stb |-> $stable(word_out));
  // R3
  hsync_flip_chk: assert property (@(posedge clk) disable iff (rst)
    det |=> (hsync != $past(hsync)));
  // R9
  hsync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !det |=> $stable(hsync));
endmodule

// File: rtl/sdi_word_aligner.sv
module sdi_word_aligner #(
  parameter int WORD_W = 10,
  parameter int PRE_WORDS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              corr_en,
  output logic [WORD_W-1:0] word_out,
  output logic              word_stb,
  output logic              hsync,
  output logic              sync_err
);
  localparam int TOT = WORD_W * PRE_WORDS;

  logic [TOT-1:0] sr_nxt;
  logic           det;
  logic           miss;
  logic           capture;

  sdia_shift_det #(.W(WORD_W), .N(PRE_WORDS)) i_shift (
    .clk    (clk),
    .rst    (rst),
    .bit_in (bit_in),
    .sr_nxt (sr_nxt),
    .det    (det)
  );

  sdia_phase_ctrl #(.W(WORD_W)) i_phase (
    .clk     (clk),
    .rst     (rst),
    .det     (det),
    .corr_en (corr_en),
    .miss    (miss),
    .capture (capture)
  );

  sdia_word_out #(.W(WORD_W)) i_out (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .word_in  (sr_nxt[TOT-1 -: WORD_W]),
    .det      (det),
    .miss     (miss),
    .word_out (word_out),
    .word_stb (word_stb),
    .hsync    (hsync),
    .sync_err (sync_err)
  );
endmodule

// File: tb/test_sdi_word_aligner.sv
module test_sdi_word_aligner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_in = 1'b0;
  logic       corr_en = 1'b0;
  logic [9:0] word_out;
  logic       word_stb, hsync, sync_err;

  always #10 clk = ~clk;

  sdi_word_aligner i_sdi_word_aligner (
    .clk(clk), .rst(rst), .bit_in(bit_in), .corr_en(corr_en),
    .word_out(word_out), .word_stb(word_stb), .hsync(hsync), .sync_err(sync_err)
  );

  localparam logic [29:0] PRE = {20'h0, 10'h3FF};

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic chk_en = 1'b0;
  string cur_req = "R1";

  // reference state, written from the requirements
  logic [29:0] m_sr;
  int          m_cnt;
  logic        m_pend;
  logic        exp_stb, exp_hs, exp_err;
  logic [9:0]  exp_q[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares outputs against the scoreboard away from the edge
  always @(posedge clk) begin
    #5;
    if (chk_en) begin
      check(cur_req, "word_stb", int'(word_stb), int'(exp_stb));
      if (exp_stb) begin
        if (exp_q.size() == 0) check(cur_req, "queue empty", 1, 0);
        else check(cur_req, "word_out", int'(word_out), int'(exp_q.pop_front()));
      end
      check(cur_req, "hsync", int'(hsync), int'(exp_hs));
      check(cur_req, "sync_err", int'(sync_err), int'(exp_err));
    end
  end

  // driver: drives one bit at a falling edge and updates the reference
  task automatic send_bit(input logic b);
    logic [29:0] n;
    logic det, onb, rea;
    bit_in = b;
    chk_en = 1'b1;
    n = {b, m_sr[29:1]};
    det = (n == PRE);
    onb = (m_cnt == 9);
    rea = 1'b0;
    exp_err = 1'b0;
    if (det) begin
      exp_hs = ~exp_hs;
      if (onb) m_pend = 1'b0;
      else begin
        exp_err = 1'b1;
        if (corr_en && !m_pend) m_pend = 1'b1;
        else begin rea = 1'b1; m_pend = 1'b0; end
      end
    end
    exp_stb = onb || rea;
    if (exp_stb) exp_q.push_back(n[29:20]);
    m_cnt = exp_stb ? 0 : m_cnt + 1;
    m_sr = n;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) send_bit(w[i]);
  endtask

  task automatic send_pre();
    send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
  endtask

  task automatic pad(input int k);
    for (int i = 0; i < k; i++) send_bit(1'b0);
  endtask

  task automatic do_reset(input logic c);
    chk_en = 1'b0;
    if (exp_q.size() != 0) check(cur_req, "leftover words", exp_q.size(), 0);
    rst = 1'b1; corr_en = c; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_sr = '0; m_cnt = 0; m_pend = 1'b0;
    exp_stb = 1'b0; exp_hs = 1'b0; exp_err = 1'b0;
    exp_q.delete();
    check("R1", "reset word_out", int'(word_out), 0);
    check("R1", "reset word_stb", int'(word_stb), 0);
    check("R1", "reset hsync", int'(hsync), 0);
    check("R1", "reset sync_err", int'(sync_err), 0);
  endtask

  initial begin
    @(negedge clk);
    // R1 / R2: plain data, first word from first ten bits, LSB first
    cur_req = "R1"; do_reset(1'b0);
    send_word(10'h155);
    cur_req = "R2";
    send_word(10'h2AA); send_word(10'h001); send_word(10'h200);
    send_word(10'h3C7); send_word(10'h0F0);
    // R3 / R4: aligned preamble, no error, timing unchanged
    cur_req = "R3"; send_pre();
    cur_req = "R4"; send_word(10'h123); send_word(10'h2DB);
    // R5: correction off, misaligned preamble realigns immediately
    cur_req = "R5"; do_reset(1'b0);
    send_word(10'h0A5); pad(3); send_pre();
    send_word(10'h1E1); send_word(10'h35A); send_word(10'h00F);
    // R6 / R9: correction on, first miss ignored, hsync still toggles
    cur_req = "R6"; do_reset(1'b1);
    send_word(10'h0C3); pad(4); send_pre();
    cur_req = "R9"; send_word(10'h111); send_word(10'h222);
    // R7: second consecutive miss realigns
    cur_req = "R7"; send_pre();
    send_word(10'h333); send_word(10'h0AB); send_word(10'h155);
    // R8: aligned preamble between two misses clears the pending state
    cur_req = "R8"; do_reset(1'b1);
    send_word(10'h066); pad(3); send_pre();
    pad(7); send_pre();
    send_word(10'h2F0); pad(5); send_pre();
    send_word(10'h0D4); send_word(10'h19B); send_word(10'h3E0);
    chk_en = 1'b0;
    check("R8", "leftover words", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule